// File: doc/BRIEF.md
# Bus Output Port with Hex Digit Drivers

This block is an output peripheral on a processor's peripheral bus. It holds four 8-bit output registers. One register drives a row of LEDs directly. The other three each feed two seven-segment digits. Each digit has its own hex decoder, so software writes plain binary bytes and every nibble shows up as a glyph from 0 to F. The registers are packed two per 16-bit bus word. Each byte lane of a word can be written on its own, and every register can be read back.

The bus is the plain single-cycle peripheral protocol. A transfer is active in any cycle where `bus_en` is high, and `bus_addr` is a word address counted from the start of the peripheral space. A non-zero byte mask on `bus_we` makes the transfer a write, which takes effect at the same clock edge. An all-zero mask makes it a read, and the data appears on `bus_rdata` in the following cycle. The protocol has no handshake, so there is no valid/ready interface and no back-pressure: every transfer completes in fixed time. Whenever the block returns no read data, `bus_rdata` is zero. This lets the system OR it with the read data of the other peripherals.

The block occupies two word addresses starting at `BASE_WORD`.
- Word `BASE_WORD+0`:
  - bits [7:0] hold the LED port;
  - bits [15:8] hold the port shown on digits 0 (low nibble) and 1 (high nibble).
- Word `BASE_WORD+1`:
  - bits [7:0] hold the port shown on digits 2 (low nibble) and 3 (high nibble);
  - bits [15:8] hold the port shown on digits 4 (low nibble) and 5 (high nibble).

Top module: `hexport_top`

## Requirements
- R1: On reset, all four output registers become zero. As a result `led_out` is 0, every digit shows the glyph for 0 (7'h40) and `bus_rdata` is 0.
- R2: A write with `bus_we` = 2'b11 to word 0 loads the LED port from bits [7:0] and the digit-0/1 port from bits [15:8]. The new values are visible on the outputs right after the clock edge of that write.
- R3: `bus_we[0]` enables a write of byte lane [7:0] and `bus_we[1]` enables a write of byte lane [15:8]. A byte lane whose mask bit is 0 keeps its old value.
- R4: A read (`bus_en` = 1, `bus_we` = 2'b00) to an address inside the block puts the addressed word, laid out as in the map above, on `bus_rdata` during the next cycle only. A read issued in the cycle right after a write to the same word returns the newly written value.
- R5: In the cycle after any cycle that was not a read hitting the block, `bus_rdata` is 0. This covers idle cycles, writes and reads outside the block.
- R6: A transfer whose address lies outside `BASE_WORD` to `BASE_WORD+1` changes no register.
- R7: Digit k (k = 0..5) shows nibble k mod 2 of port k/2 + 1. Ports are numbered 0 = LED, 1 = word 0 high byte, 2 = word 1 low byte, 3 = word 1 high byte. Digit k drives bits [7k+6:7k] of `hex_seg_n`.
- R8: Each digit is 7 active-low segment bits in the order {g,f,e,d,c,b,a}. The active-high patterns for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, and the outputs carry their inverse.
- R9: While `bus_en` is 0, `bus_we`, `bus_addr` and `bus_wdata` have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Transfer active this cycle |
| bus_we | input | 2 | Byte write mask, 2'b00 means read |
| bus_addr | input | ADDR_W | Word address relative to the peripheral space |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is returned |
| led_out | output | 8 | LED port register |
| hex_seg_n | output | 42 | Six digits of 7 active-low segments, digit 0 in the low bits |

## Verification
The readback register and the write path can be busy in the same cycle in two ways. In the first, a read of a word is followed at once by a write to that same word. The bench samples `bus_rdata` while the write is on the bus and expects the value from before the write; one cycle later it expects zero. In the second, a write is followed at once by a read of the same word, and the returned data must already hold the freshly written bytes. A table of mixed transfers with partial masks and addresses outside the block exercises the remaining cases. After that, a sweep of all sixteen nibble values checks each digit's glyph against a segment table held in the bench.

// File: rtl/hexport_pkg.sv
package hexport_pkg;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int N_LANES  = DATA_W / BYTE_W;
  localparam int N_WORDS  = 2;
  localparam int N_PORTS  = N_WORDS * N_LANES;
  localparam int NIB_W    = 4;
  localparam int SEG_W    = 7;
  localparam int DIGITS_PER_PORT = BYTE_W / NIB_W;
  localparam int N_DISP_PORTS    = N_PORTS - 1;
  localparam int N_DIGITS = N_DISP_PORTS * DIGITS_PER_PORT;
  localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  typedef logic [N_WORDS-1:0][DATA_W-1:0] word_bank_t;
endpackage

// File: rtl/hexport_seg_decode.sv
module hexport_seg_decode
  import hexport_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SEG_W-1:0] seg_n
);
  // segment order {g,f,e,d,c,b,a}, low = lit
  always_comb begin
    case (nib)
      4'h0: seg_n = 7'h40;
      4'h1: seg_n = 7'h79;
      4'h2: seg_n = 7'h24;
      4'h3: seg_n = 7'h30;
      4'h4: seg_n = 7'h19;
      4'h5: seg_n = 7'h12;
      4'h6: seg_n = 7'h02;
      4'h7: seg_n = 7'h78;
      4'h8: seg_n = 7'h00;
      4'h9: seg_n = 7'h10;
      4'hA: seg_n = 7'h08;
      4'hB: seg_n = 7'h03;
      4'hC: seg_n = 7'h46;
      4'hD: seg_n = 7'h21;
      4'hE: seg_n = 7'h06;
      default: seg_n = 7'h0E;
    endcase
  end
endmodule

// File: rtl/hexport_regbank.sv
module hexport_regbank
  import hexport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [N_LANES-1:0] wr_mask,
  input  logic [DATA_W-1:0]  wr_data,
  output word_bank_t         word_q
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic lane_wr;
      assign lane_wr = wr_en && (wr_idx == IDX_W'(w)) && wr_mask[l];

      always_ff @(posedge clk) begin
        if (!rst_n)
          word_q[w][l*BYTE_W +: BYTE_W] <= '0;
        else if (lane_wr)
          word_q[w][l*BYTE_W +: BYTE_W] <= wr_data[l*BYTE_W +: BYTE_W];
      end

      // R3
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_idx == IDX_W'(w)) && wr_mask[l])
          |=> $stable(word_q[w][l*BYTE_W +: BYTE_W]));

      // R2
      lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(w)) && wr_mask[l])
          |=> word_q[w][l*BYTE_W +: BYTE_W] == $past(wr_data[l*BYTE_W +: BYTE_W]));
    end
  end
endmodule

// File: rtl/hexport_readback.sv
module hexport_readback
  import hexport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  word_bank_t        word_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= word_q[rd_idx];
    else             rdata <= '0;
  end

  // R4
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rdata == $past(word_q[rd_idx]));

  // R5
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> rdata == '0);
endmodule

// File: rtl/hexport_top.sv
module hexport_top
  import hexport_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_WORD = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_en,
  input  logic [1:0]                  bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [15:0]                 bus_wdata,
  output logic [15:0]                 bus_rdata,
  output logic [7:0]                  led_out,
  output logic [N_DIGITS*SEG_W-1:0]   hex_seg_n
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(N_WORDS);

  logic [ADDR_W-1:0] offs;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic              wr_go;
  logic              rd_go;
  word_bank_t        word_q;
  logic [N_WORDS*DATA_W-1:0] flat_q;

  assign offs    = bus_addr - BASE_A;
  assign sel_hit = offs < SPAN_A;
  assign sel_idx = offs[IDX_W-1:0];
  assign wr_go   = bus_en && sel_hit && (|bus_we);
  assign rd_go   = bus_en && sel_hit && !(|bus_we);

  hexport_regbank i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_go),
    .wr_idx  (sel_idx),
    .wr_mask (bus_we),
    .wr_data (bus_wdata),
    .word_q  (word_q)
  );

  hexport_readback i_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (rd_go),
    .rd_idx (sel_idx),
    .word_q (word_q),
    .rdata  (bus_rdata)
  );

  assign flat_q  = word_q;
  assign led_out = flat_q[BYTE_W-1:0];

  for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
    localparam int PORT_I = d / DIGITS_PER_PORT + 1;
    localparam int NIB_I  = d % DIGITS_PER_PORT;
    hexport_seg_decode i_dec (
      .nib   (flat_q[PORT_I*BYTE_W + NIB_I*NIB_W +: NIB_W]),
      .seg_n (hex_seg_n[d*SEG_W +: SEG_W])
    );

    // R8
    glyph_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~hex_seg_n[d*SEG_W +: SEG_W]) >= 2);
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(word_q));

  // R6
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !sel_hit) |=> $stable(word_q));
endmodule

// File: tb/test_hexport_top.sv
module test_hexport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic [1:0]  bus_we = 2'b00;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [7:0]  led_out;
  logic [41:0] hex_seg_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hexport_top i_hexport_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_out(led_out), .hex_seg_n(hex_seg_n)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  we;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b11, 8'h00, 16'hA55A, 16'h0000}, // R2 full word
    '{1'b1, 2'b00, 8'h00, 16'h0000, 16'hA55A}, // R4
    '{1'b0, 2'b01, 8'h01, 16'h1234, 16'h0000}, // R3 low lane
    '{1'b0, 2'b10, 8'h01, 16'hBEEF, 16'h0000}, // R3 high lane
    '{1'b1, 2'b00, 8'h01, 16'h0000, 16'hBE34}, // R3 R4
    '{1'b0, 2'b10, 8'h00, 16'h7700, 16'h0000}, // R3
    '{1'b1, 2'b00, 8'h00, 16'h0000, 16'h775A}, // R3 R4
    '{1'b0, 2'b11, 8'h02, 16'hFFFF, 16'h0000}, // R6 outside
    '{1'b1, 2'b00, 8'h02, 16'h0000, 16'h0000}, // R5 read outside
    '{1'b0, 2'b11, 8'h80, 16'h1111, 16'h0000}, // R6 outside
    '{1'b1, 2'b00, 8'h00, 16'h0000, 16'h775A}  // R6 unchanged
  };

  function automatic logic [6:0] glyph(input logic [3:0] n);
    logic [6:0] hi;
    case (n)
      4'h0: hi = 7'h3F; 4'h1: hi = 7'h06; 4'h2: hi = 7'h5B; 4'h3: hi = 7'h4F;
      4'h4: hi = 7'h66; 4'h5: hi = 7'h6D; 4'h6: hi = 7'h7D; 4'h7: hi = 7'h07;
      4'h8: hi = 7'h7F; 4'h9: hi = 7'h6F; 4'hA: hi = 7'h77; 4'hB: hi = 7'h7C;
      4'hC: hi = 7'h39; 4'hD: hi = 7'h5E; 4'hE: hi = 7'h79; default: hi = 7'h71;
    endcase
    return ~hi;
  endfunction

  function automatic logic [6:0] digit(input int k);
    return hex_seg_n[k*7 +: 7];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 2'b00; bus_wdata = 16'h0000;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "led", 32'(led_out), 32'h0);
    chk("R1", "rdata", 32'(bus_rdata), 32'h0);
    for (int k = 0; k < 6; k++) chk("R1", "digit", 32'(digit(k)), 32'h40);

    // table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].rd ? 2'b00 : VECS[i].we, VECS[i].addr, VECS[i].data);
      if (VECS[i].rd) chk("R4", $sformatf("vector %0d rdata", i),
                          32'(bus_rdata), 32'(VECS[i].exp));
    end
    // ports now: led 5A, p1 77, p2 34, p3 BE
    chk("R2", "led after table", 32'(led_out), 32'h5A);
    chk("R7", "digit0", 32'(digit(0)), 32'(glyph(4'h7)));
    chk("R7", "digit1", 32'(digit(1)), 32'(glyph(4'h7)));
    chk("R7", "digit2", 32'(digit(2)), 32'(glyph(4'h4)));
    chk("R7", "digit3", 32'(digit(3)), 32'(glyph(4'h3)));
    chk("R7", "digit4", 32'(digit(4)), 32'(glyph(4'hE)));
    chk("R7", "digit5", 32'(digit(5)), 32'(glyph(4'hB)));

    // R5 idle cycle returns zero
    @(negedge clk);
    chk("R5", "idle rdata", 32'(bus_rdata), 32'h0);

    // R9 enable low ignores strobes
    @(negedge clk);
    bus_en = 1'b0; bus_we = 2'b11; bus_addr = 8'h00; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_we = 2'b00;
    chk("R9", "led held", 32'(led_out), 32'h5A);
    chk("R9", "digit1 held", 32'(digit(1)), 32'(glyph(4'h7)));

    // R4 write then read of same word back to back
    @(negedge clk);
    bus_en = 1'b1; bus_we = 2'b11; bus_addr = 8'h00; bus_wdata = 16'hC3C3;
    @(negedge clk);
    bus_we = 2'b00;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R4", "read after write", 32'(bus_rdata), 32'hC3C3);

    // R4/R5 read then write of same word back to back
    @(negedge clk);
    bus_en = 1'b1; bus_we = 2'b00; bus_addr = 8'h01;
    @(negedge clk);
    bus_we = 2'b11; bus_wdata = 16'h0F0F;
    chk("R4", "old data during write", 32'(bus_rdata), 32'hBE34);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 2'b00;
    chk("R5", "rdata after write", 32'(bus_rdata), 32'h0);

    // R8 glyph sweep on digits 0 and 1
    for (int v = 0; v < 16; v++) begin
      xfer(2'b10, 8'h00, {4'(v), 4'(15 - v), 8'h00});
      chk("R8", $sformatf("digit0 nib %0d", 15 - v), 32'(digit(0)), 32'(glyph(4'(15 - v))));
      chk("R8", $sformatf("digit1 nib %0d", v), 32'(digit(1)), 32'(glyph(4'(v))));
    end
    chk("R3", "led untouched by sweep", 32'(led_out), 32'hC3);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "led after reset", 32'(led_out), 32'h0);
    chk("R1", "digit5 after reset", 32'(digit(5)), 32'h40);
    xfer(2'b00, 8'h01, 16'h0000);
    chk("R1", "word1 after reset", 32'(bus_rdata), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule